// File: doc/BRIEF.md
# Line-Change Timestamp Engine

This block watches a set of input lines, organised as groups of 32, and records every level change on an enabled line. Each record holds the 64-bit system time, the number of the line that changed and the level it changed to. Records go into an internal FIFO. Software drains the FIFO through a small word-addressed register port. The block raises one level interrupt when the FIFO holds at least a programmable number of records, so software is not interrupted once per change.

Each line enters through a two-flop synchroniser. A change is found by comparing the synchronised level with its value one cycle earlier. A detected change on an enabled line sets a per-line pending bit. On each cycle the lowest-numbered pending line is moved into the FIFO together with the system time of that cycle. Software reads the two timestamp halves of the oldest record without popping it, then reads the event word, which pops the record.

Register map (word addresses):

| Address | Content |
|---|---|
| `s` (0 to NSLICE-1) | enable group `s`. Bit `b` enables line `32*s+b`. |
| 0x40 | interrupt threshold |
| 0x41 | status. Bit 0 is overflow (write 1 to clear), bit 1 is the interrupt, bits [31:16] are the occupancy. |
| 0x42 | timestamp bits [31:0] |
| 0x43 | timestamp bits [63:32] |
| 0x44 | event word. Bit 31 is the new level, bit 30 is valid, bits [15:0] are the line number. Reading it pops the record. |

Reads return data on `reg_rdata` one cycle after `reg_rd`.

Top module: `line_stamp_engine`

## Requirements
- R1: After reset the FIFO is empty, `irq` is low, all enables are zero, the threshold reads 1 and the overflow bit is 0.
- R2: A rising or a falling change on an enabled line produces exactly one record. The record carries the line number in event bits [15:0], the new level in bit 31, and bit 30 set.
- R3: For a change with nothing else pending, the timestamp equals the `sys_time` value present just before the third rising edge after the edge that first samples the change. The timestamp is read as two 32-bit halves at 0x42 (low) and 0x43 (high).
- R4: A change on a line whose enable bit is 0 produces no record. Bit `b` of the enable word at address `s` controls line `32*s+b`.
- R5: Changes on several enabled lines in the same cycle are stored one per cycle, lowest line number first, with timestamps that increase by 1 from record to record.
- R6: A threshold write of 0 stores 1, a write above 256 stores 256, and any other value is stored as written.
- R7: `irq` is high exactly while the occupancy is at least the threshold, and it falls once a pop brings the occupancy below the threshold.
- R8: When the FIFO already holds DEPTH records, a further change is dropped and the overflow bit is set. The overflow bit stays set until software writes 1 to status bit 0.
- R9: Reading 0x42 or 0x43 does not pop. Reading the event word pops one record. Reading the event word while the FIFO is empty returns 0 with bit 30 clear and changes nothing.
- R10: Clearing a line's enable bit discards a change that is pending for that line and not yet stored.
- R11: Status bit 1 mirrors `irq`, and status bits [31:16] give the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_in | input | NSLICE*32 | Monitored lines, asynchronous to `clk` |
| sys_time | input | 64 | Free-running system time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level interrupt: occupancy at or above the threshold |

## Verification
The main function is tried with four input patterns:
- **Single isolated change, rising then falling.** This pins the detection latency and the captured time. It also shows that both directions are recorded with the correct level.
- **One cycle with changes on lines in every group, mixed with a disabled line.** This separates correct lowest-first ordering and group decoding from a wrong order or a leaking enable.
- **Enable cleared while changes are still queued.** This shows the difference between records that were already stored and pending changes that must be discarded.
- **A long run of changes on one line past the FIFO depth.** This tells a correct drop-and-flag from a wrap-around that overwrites the oldest records.

// File: rtl/line_stamp_engine.sv
module line_stamp_engine #(
  parameter int NSLICE = 3,
  parameter int DEPTH  = 16,
  parameter int AW     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLICE*32-1:0]   lines_in,
  input  logic [63:0]            sys_time,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [AW-1:0]          reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   irq
);
  localparam int NL = NSLICE * 32;
  localparam int IW = $clog2(NL);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_THR = AW'(8'h40);
  localparam logic [AW-1:0] A_STA = AW'(8'h41);
  localparam logic [AW-1:0] A_TLO = AW'(8'h42);
  localparam logic [AW-1:0] A_THI = AW'(8'h43);
  localparam logic [AW-1:0] A_EVT = AW'(8'h44);

  logic [NL-1:0] s1, s2, prv, en, pend, plv, chg, clr;
  logic [8:0]    thr;
  logic          ovf;
  logic [63:0]   ts_m [DEPTH];
  logic [IW-1:0] id_m [DEPTH];
  logic          lv_m [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [IW-1:0] sel;
  logic          sel_v, full, do_wr, drop, pop;

  assign chg   = s2 ^ prv;
  assign full  = (cnt == CW'(DEPTH));
  assign do_wr = sel_v && !full;
  assign drop  = sel_v && full;
  assign pop   = reg_rd && (reg_addr == A_EVT) && (cnt != '0);
  assign clr   = sel_v ? (NL'(1) << sel) : '0;
  assign irq   = (32'(cnt) >= 32'(thr));

  always_comb begin
    sel_v = 1'b0;
    sel   = '0;
    for (int i = 0; i < NL; i++)
      if (pend[i] && !sel_v) begin
        sel_v = 1'b1;
        sel   = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prv <= '0; pend <= '0; plv <= '0;
    end else begin
      s1   <= lines_in;
      s2   <= s1;
      prv  <= s2;
      pend <= ((pend & ~clr) | (chg & en)) & en;
      for (int i = 0; i < NL; i++)
        if (chg[i]) plv[i] <= s2[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= '0;
      thr <= 9'd1;
      ovf <= 1'b0;
    end else begin
      if (reg_wr) begin
        for (int s = 0; s < NSLICE; s++)
          if (reg_addr == AW'(s)) en[s*32 +: 32] <= reg_wdata;
        if (reg_addr == A_THR)
          thr <= (reg_wdata == 32'd0)   ? 9'd1 :
                 (reg_wdata > 32'd256)  ? 9'd256 : reg_wdata[8:0];
      end
      if (drop) ovf <= 1'b1;
      else if (reg_wr && reg_addr == A_STA && reg_wdata[0]) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      ts_m[wp] <= sys_time;
      id_m[wp] <= sel;
      lv_m[wp] <= plv[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)   rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      reg_rdata <= '0;
      for (int s = 0; s < NSLICE; s++)
        if (reg_addr == AW'(s)) reg_rdata <= en[s*32 +: 32];
      case (reg_addr)
        A_THR: reg_rdata <= 32'(thr);
        A_STA: reg_rdata <= {16'(cnt), 14'd0, irq, ovf};
        A_TLO: reg_rdata <= (cnt != '0) ? ts_m[rp][31:0]  : 32'd0;
        A_THI: reg_rdata <= (cnt != '0) ? ts_m[rp][63:32] : 32'd0;
        A_EVT: reg_rdata <= (cnt != '0) ? {lv_m[rp], 1'b1, 14'd0, 16'(id_m[rp])} : 32'd0;
        default: ;
      endcase
    end
  end

  a_r6_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
    thr >= 9'd1 && thr <= 9'd256);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(reg_wr && reg_addr == A_STA && reg_wdata[0]) |=> ovf);

  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full && sel_v && !pop |=> ovf && cnt == $past(cnt));

  a_r5_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (32'(cnt) <= 32'($past(cnt)) + 1) && (32'(cnt) <= DEPTH));

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(0) && reg_wdata == 32'd0 |=> ##1 pend[31:0] == 32'd0);

  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == A_EVT && cnt == '0 |=> reg_rdata[30] == 1'b0 && cnt == '0 || $past(sel_v));
endmodule

// File: tb/line_stamp_engine_bench.sv
module line_stamp_engine_bench;
  localparam int NSLICE = 3;
  localparam int DEPTH  = 16;
  localparam int AW     = 8;
  localparam int NL     = NSLICE * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [63:0] time_q = 64'h0000_0002_FFFF_FF80;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [NL-1:0] en_m = '0;

  typedef struct { int line; bit lvl; logic [63:0] ts; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) time_q <= time_q + 64'd1;

  line_stamp_engine #(.NSLICE(NSLICE), .DEPTH(DEPTH), .AW(AW)) u_line_stamp_engine (
    .clk(clk), .rst_n(rst_n), .lines_in(lines), .sys_time(time_q),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic set_en(int s, logic [31:0] v);
    wr_reg(AW'(s), v);
    en_m[s*32 +: 32] = v;
  endtask

  task automatic toggle(logic [NL-1:0] mask, bit push);
    logic [63:0] v;
    int k = 0;
    @(negedge clk);
    v = time_q;
    lines = lines ^ mask;
    if (push)
      for (int i = 0; i < NL; i++)
        if (mask[i] && en_m[i]) begin
          if (q.size() < DEPTH) q.push_back('{i, lines[i], v + 64'd3 + 64'(k)});
          k++;
        end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(int n, string req);
    logic [31:0] lo, hi, ev;
    exp_t e;
    for (int j = 0; j < n; j++) begin
      rd_reg(AW'(8'h42), lo);
      rd_reg(AW'(8'h43), hi);
      rd_reg(AW'(8'h44), ev);
      if (q.size() == 0) begin
        check(0, {req, " unexpected record"}, 64'(ev), 0);
      end else begin
        e = q.pop_front();
        check(ev[30] == 1'b1, {req, " valid"}, 64'(ev[30]), 1);
        check(int'(ev[15:0]) == e.line, {req, " line"}, 64'(ev[15:0]), 64'(e.line));
        check(ev[31] == e.lvl, {req, " level"}, 64'(ev[31]), 64'(e.lvl));
        check({hi, lo} == e.ts, {req, " R3 timestamp"}, {hi, lo}, e.ts);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);

    check(irq == 1'b0, "R1 irq", 64'(irq), 0);
    rd_reg(AW'(8'h41), d); check(d == 0, "R1 status", 64'(d), 0);
    rd_reg(AW'(8'h40), d); check(d == 1, "R1 threshold", 64'(d), 1);
    rd_reg(AW'(0), d);     check(d == 0, "R1 enable", 64'(d), 0);
    rd_reg(AW'(8'h44), d); check(d == 0, "R9 empty read", 64'(d), 0);

    toggle(NL'(1) << 3, 1);
    wait_cyc(8);
    rd_reg(AW'(8'h41), d); check(d[31:16] == 0, "R4 disabled line", 64'(d[31:16]), 0);

    set_en(0, 32'h0000_00FF);
    set_en(1, 32'h0000_0002);
    set_en(2, 32'h8000_0001);
    rd_reg(AW'(2), d); check(d == 32'h8000_0001, "R4 enable readback", 64'(d), 64'h8000_0001);

    toggle(NL'(1) << 2, 1); wait_cyc(8); drain(1, "R2 rising");
    toggle(NL'(1) << 2, 1); wait_cyc(8); drain(1, "R2 falling");

    toggle((NL'(1) << 0) | (NL'(1) << 5) | (NL'(1) << 33) | (NL'(1) << 40) |
           (NL'(1) << 64) | (NL'(1) << 95), 1);
    wait_cyc(12);
    rd_reg(AW'(8'h41), d); check(d[31:16] == 5, "R11 occupancy", 64'(d[31:16]), 5);
    rd_reg(AW'(8'h42), d);
    rd_reg(AW'(8'h41), d); check(d[31:16] == 5, "R9 peek no pop", 64'(d[31:16]), 5);
    drain(5, "R5 order");

    wr_reg(AW'(8'h40), 32'd0);   rd_reg(AW'(8'h40), d); check(d == 1, "R6 zero", 64'(d), 1);
    wr_reg(AW'(8'h40), 32'd300); rd_reg(AW'(8'h40), d); check(d == 256, "R6 high", 64'(d), 256);
    wr_reg(AW'(8'h40), 32'd3);   rd_reg(AW'(8'h40), d); check(d == 3, "R6 mid", 64'(d), 3);

    toggle(NL'(1) << 1, 1); wait_cyc(8);
    toggle(NL'(1) << 1, 1); wait_cyc(8);
    check(irq == 1'b0, "R7 below", 64'(irq), 0);
    toggle(NL'(1) << 1, 1); wait_cyc(8);
    check(irq == 1'b1, "R7 at threshold", 64'(irq), 1);
    rd_reg(AW'(8'h41), d); check(d[1] == 1'b1, "R11 irq bit", 64'(d[1]), 1);
    drain(1, "R7 pop");
    check(irq == 1'b0, "R7 fall", 64'(irq), 0);
    drain(2, "R7 rest");
    wr_reg(AW'(8'h40), 32'd1);

    begin
      logic [63:0] v;
      @(negedge clk);
      v = time_q;
      lines = lines ^ NL'(32'hFF);
      q.push_back('{0, lines[0], v + 64'd3});
      q.push_back('{1, lines[1], v + 64'd4});
      wait_cyc(2);
      set_en(0, 32'h0000_0003);
      wait_cyc(12);
      rd_reg(AW'(8'h41), d); check(d[31:16] == 2, "R10 pending dropped", 64'(d[31:16]), 2);
      drain(2, "R10 stored");
      set_en(0, 32'h0000_00FF);
    end

    for (int n = 0; n < DEPTH + 1; n++) begin
      toggle(NL'(1) << 64, 1);
      wait_cyc(6);
    end
    rd_reg(AW'(8'h41), d);
    check(d[0] == 1'b1, "R8 overflow set", 64'(d[0]), 1);
    check(d[31:16] == DEPTH, "R8 occupancy full", 64'(d[31:16]), DEPTH);
    drain(DEPTH, "R8 kept");
    rd_reg(AW'(8'h44), d); check(d[30] == 1'b0, "R8 nothing extra", 64'(d), 0);
    rd_reg(AW'(8'h41), d); check(d[0] == 1'b1, "R8 sticky", 64'(d[0]), 1);
    wr_reg(AW'(8'h41), 32'd1);
    rd_reg(AW'(8'h41), d); check(d[0] == 1'b0, "R8 clear", 64'(d[0]), 0);

    check(q.size() == 0, "scoreboard empty", 64'(q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule